// File: doc/BRIEF.md
# Two-Source Memory Request Arbiter

This block sits in front of a DRAM controller and merges requests from two 64-bit masters. The first is a shared system bus. Its commands wait in a short transaction queue. Write beats for those commands are staged in a write buffer, and returned read beats are staged in a read buffer. The second master is a CPU port with lower latency. Its commands are not queued, and its read data never passes through the read buffer.

Whenever no burst is in flight, the block picks between the pending CPU command and the oldest queued system-bus command. The CPU command always wins. The chosen transaction is then issued to the controller one beat at a time over a valid/ready command channel. Each beat carries a source tag. The controller returns each read beat with that tag after a fixed latency, and the tag routes the data either straight to the CPU port or into the read buffer. Lengths are given in beats. A command whose length is out of range is refused with an error pulse and never issued.

Top module: `mr_arbiter`

## Requirements
- R1: If no burst is in flight, and a valid-length CPU command and a queued system-bus command are both waiting, the CPU command is issued first.
- R2: A granted burst issues all of its beats before any other transaction starts. A CPU command that arrives during a queued burst waits until that burst's final beat.
- R3: `sb_req_ready` is low while the queued commands plus the issued system-bus reads not yet fully drained add up to 4. It rises in the cycle after the final beat of the oldest such read is taken by the requester.
- R4: `dn_tag` is 1 on beats of CPU transactions and 0 on beats of system-bus transactions. `dn_rtag` uses the same encoding to route returned data.
- R5: A returned beat with `dn_rtag`=1 appears on `cpu_rvalid`/`cpu_rdata` in the same cycle and never enters the read buffer.
- R6: System-bus read data leaves on `sb_rdata` in the order the reads were issued. `sb_rlast` marks the final beat of each transaction.
- R7: The length must be 1 to 16 on the system bus and 1 to 4 on the CPU port. An accepted command outside this range gives a one-cycle `sb_err` or `cpu_err` and issues no beat. Length 16 on the system bus and length 4 on the CPU port are accepted.
- R8: Beat i of a transaction starting at address A carries `dn_addr` = A + 8*i. `dn_last` is high only on the final beat.
- R9: A queued system-bus write is not issued until all of its data beats are in the write buffer. Its beats then carry that data in arrival order.
- R10: After reset, `dn_valid`, `sb_rvalid` and `cpu_req_ready` are low and `sb_req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sb_req_valid | input | 1 | System-bus command valid |
| sb_req_ready | output | 1 | System-bus command accepted |
| sb_req_write | input | 1 | 1 = write, 0 = read |
| sb_req_addr | input | 32 | Start byte address |
| sb_req_len | input | 5 | Length in beats |
| sb_err | output | 1 | Accepted command refused for bad length |
| sb_wvalid | input | 1 | System-bus write beat valid |
| sb_wready | output | 1 | Write buffer has room |
| sb_wdata | input | 64 | Write beat |
| sb_rvalid | output | 1 | Read buffer beat valid |
| sb_rready | input | 1 | Requester takes read beat |
| sb_rdata | output | 64 | Read beat |
| sb_rlast | output | 1 | Final beat of a read transaction |
| cpu_req_valid | input | 1 | CPU command valid |
| cpu_req_ready | output | 1 | CPU command accepted |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | 32 | Start byte address |
| cpu_req_len | input | 5 | Length in beats |
| cpu_err | output | 1 | Accepted command refused for bad length |
| cpu_wvalid | input | 1 | CPU write beat available |
| cpu_wready | output | 1 | CPU write beat consumed |
| cpu_wdata | input | 64 | CPU write beat |
| cpu_rvalid | output | 1 | CPU read beat |
| cpu_rdata | output | 64 | CPU read data |
| dn_valid | output | 1 | Beat command valid |
| dn_ready | input | 1 | Controller accepts beat |
| dn_write | output | 1 | Beat is a write |
| dn_addr | output | 32 | Beat address |
| dn_wdata | output | 64 | Beat write data |
| dn_tag | output | 1 | Source tag |
| dn_last | output | 1 | Final beat of transaction |
| dn_rvalid | input | 1 | Returned read beat valid |
| dn_rtag | input | 1 | Source tag of returned beat |
| dn_rdata | input | 64 | Returned read data |

## Verification
The bench builds the block with its default parameters: a queue depth of 4, system-bus bursts of up to 16 beats, CPU bursts of up to 4 beats, 32-bit addresses and 64-bit data. At these values, two 16-beat reads plus two short reads fill all four slots with the requester stalled. This puts 35 beats in the read buffer and lets the bench observe the exact cycle in which ready comes back. Both length limits, and the values one past them, can also be reached directly with these defaults.

// File: rtl/mr_pkg.sv
package mr_pkg;
    typedef enum logic {
        SRC_SB  = 1'b0,
        SRC_CPU = 1'b1
    } src_e;
endpackage

// File: rtl/mr_fifo.sv
module mr_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [W-1:0] mem [DEPTH];

    always_comb begin
        st_d = st_q;
        if (push) st_d.wr = (st_q.wr == PW'(DEPTH - 1)) ? '0 : st_q.wr + PW'(1);
        if (pop)  st_d.rd = (st_q.rd == PW'(DEPTH - 1)) ? '0 : st_q.rd + PW'(1);
        st_d.cnt = st_q.cnt + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem[st_q.wr] <= wdata;
    end

    assign rdata = mem[st_q.rd];
    assign count = st_q.cnt;

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (st_q.cnt != CW'(DEPTH)));

    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (st_q.cnt != '0));
endmodule

// File: rtl/mr_issue.sv
module mr_issue
    import mr_pkg::*;
#(
    parameter int AW       = 32,
    parameter int LW       = 5,
    parameter int CPU_MAXB = 4,
    parameter int WCW      = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cpu_req_valid,
    input  logic           cpu_req_write,
    input  logic [AW-1:0]  cpu_req_addr,
    input  logic [LW-1:0]  cpu_req_len,
    output logic           cpu_req_ready,
    output logic           cpu_err,
    input  logic           cpu_wvalid,
    output logic           cpu_wready,
    input  logic           q_valid,
    input  logic           q_write,
    input  logic [AW-1:0]  q_addr,
    input  logic [LW-1:0]  q_len,
    output logic           q_pop,
    input  logic [WCW-1:0] wb_count,
    output logic           wb_pop,
    output logic           rl_push,
    output logic           dn_valid,
    input  logic           dn_ready,
    output logic           dn_write,
    output logic [AW-1:0]  dn_addr,
    output logic           dn_tag,
    output logic           dn_last
);
    typedef struct packed {
        logic          busy;
        src_e          src;
        logic          wr;
        logic [AW-1:0] addr;
        logic [LW-1:0] left;
    } iss_st_t;

    iss_st_t st_d, st_q;
    logic    cpu_ok;
    logic    fire;

    assign cpu_ok = (cpu_req_len != '0) && (cpu_req_len <= LW'(CPU_MAXB));

    always_comb begin
        st_d          = st_q;
        cpu_req_ready = 1'b0;
        cpu_err       = 1'b0;
        cpu_wready    = 1'b0;
        q_pop         = 1'b0;
        wb_pop        = 1'b0;
        rl_push       = 1'b0;
        dn_valid      = 1'b0;
        fire          = 1'b0;
        dn_write      = st_q.wr;
        dn_addr       = st_q.addr;
        dn_tag        = st_q.src;
        dn_last       = (st_q.left == LW'(1));
        if (!st_q.busy) begin
            if (cpu_req_valid) begin
                cpu_req_ready = 1'b1;
                if (cpu_ok) begin
                    st_d.busy = 1'b1;
                    st_d.src  = SRC_CPU;
                    st_d.wr   = cpu_req_write;
                    st_d.addr = cpu_req_addr;
                    st_d.left = cpu_req_len;
                end else begin
                    cpu_err = 1'b1;
                end
            end else if (q_valid && (!q_write || wb_count >= WCW'(q_len))) begin
                q_pop     = 1'b1;
                rl_push   = !q_write;
                st_d.busy = 1'b1;
                st_d.src  = SRC_SB;
                st_d.wr   = q_write;
                st_d.addr = q_addr;
                st_d.left = q_len;
            end
        end else begin
            dn_valid = !(st_q.wr && (st_q.src == SRC_CPU) && !cpu_wvalid);
            fire     = dn_valid && dn_ready;
            if (fire) begin
                if (st_q.wr) begin
                    if (st_q.src == SRC_CPU) cpu_wready = 1'b1;
                    else                     wb_pop     = 1'b1;
                end
                st_d.addr = st_q.addr + AW'(8);
                st_d.left = st_q.left - LW'(1);
                if (st_q.left == LW'(1)) st_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R1
    cpu_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.busy && cpu_req_valid) |-> !q_pop);

    // R2
    burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !dn_last) |=> (st_q.busy && st_q.src == $past(st_q.src)));

    // R8
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !dn_last) |=> (dn_addr == $past(dn_addr) + AW'(8)));
endmodule

// File: rtl/mr_arbiter.sv
module mr_arbiter
    import mr_pkg::*;
#(
    parameter int AW       = 32,
    parameter int DW       = 64,
    parameter int QDEPTH   = 4,
    parameter int SB_MAXB  = 16,
    parameter int CPU_MAXB = 4,
    parameter int LW       = $clog2(SB_MAXB + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sb_req_valid,
    output logic          sb_req_ready,
    input  logic          sb_req_write,
    input  logic [AW-1:0] sb_req_addr,
    input  logic [LW-1:0] sb_req_len,
    output logic          sb_err,
    input  logic          sb_wvalid,
    output logic          sb_wready,
    input  logic [DW-1:0] sb_wdata,
    output logic          sb_rvalid,
    input  logic          sb_rready,
    output logic [DW-1:0] sb_rdata,
    output logic          sb_rlast,
    input  logic          cpu_req_valid,
    output logic          cpu_req_ready,
    input  logic          cpu_req_write,
    input  logic [AW-1:0] cpu_req_addr,
    input  logic [LW-1:0] cpu_req_len,
    output logic          cpu_err,
    input  logic          cpu_wvalid,
    output logic          cpu_wready,
    input  logic [DW-1:0] cpu_wdata,
    output logic          cpu_rvalid,
    output logic [DW-1:0] cpu_rdata,
    output logic          dn_valid,
    input  logic          dn_ready,
    output logic          dn_write,
    output logic [AW-1:0] dn_addr,
    output logic [DW-1:0] dn_wdata,
    output logic          dn_tag,
    output logic          dn_last,
    input  logic          dn_rvalid,
    input  logic          dn_rtag,
    input  logic [DW-1:0] dn_rdata
);
    localparam int BUFD = QDEPTH * SB_MAXB;
    localparam int QW   = 1 + AW + LW;
    localparam int QCW  = $clog2(QDEPTH + 1);
    localparam int BCW  = $clog2(BUFD + 1);

    typedef struct packed {
        logic [LW-1:0] taken;
    } rd_st_t;

    rd_st_t rs_d, rs_q;

    logic [QW-1:0]  q_in, q_out;
    logic [QCW-1:0] q_count, rl_count;
    logic [BCW-1:0] wb_count, rb_count;
    logic           q_push, q_pop, q_valid;
    logic           sb_ok;
    logic           wb_push, wb_pop;
    logic [DW-1:0]  wb_rdata;
    logic           rb_push, rb_pop;
    logic           rl_push, rl_pop;
    logic [LW-1:0]  rl_len;
    logic           q_write;
    logic [AW-1:0]  q_addr;
    logic [LW-1:0]  q_len;

    // command admission
    assign sb_ok        = (sb_req_len != '0) && (sb_req_len <= LW'(SB_MAXB));
    assign sb_req_ready = ((QCW+1)'(q_count) + (QCW+1)'(rl_count)) < (QCW+1)'(QDEPTH);
    assign q_push       = sb_req_valid && sb_req_ready && sb_ok;
    assign sb_err       = sb_req_valid && sb_req_ready && !sb_ok;
    assign q_in         = {sb_req_write, sb_req_addr, sb_req_len};
    assign {q_write, q_addr, q_len} = q_out;
    assign q_valid      = (q_count != '0);

    mr_fifo #(.W(QW), .DEPTH(QDEPTH), .CW(QCW)) u_cmdq (
        .clk(clk), .rst_n(rst_n), .push(q_push), .wdata(q_in),
        .pop(q_pop), .rdata(q_out), .count(q_count)
    );

    // write staging
    assign sb_wready = (wb_count != BCW'(BUFD));
    assign wb_push   = sb_wvalid && sb_wready;

    mr_fifo #(.W(DW), .DEPTH(BUFD), .CW(BCW)) u_wbuf (
        .clk(clk), .rst_n(rst_n), .push(wb_push), .wdata(sb_wdata),
        .pop(wb_pop), .rdata(wb_rdata), .count(wb_count)
    );

    // read return routing
    assign cpu_rvalid = dn_rvalid && (dn_rtag == SRC_CPU);
    assign cpu_rdata  = dn_rdata;
    assign rb_push    = dn_rvalid && (dn_rtag == SRC_SB);
    assign sb_rvalid  = (rb_count != '0);
    assign rb_pop     = sb_rvalid && sb_rready;

    mr_fifo #(.W(DW), .DEPTH(BUFD), .CW(BCW)) u_rbuf (
        .clk(clk), .rst_n(rst_n), .push(rb_push), .wdata(dn_rdata),
        .pop(rb_pop), .rdata(sb_rdata), .count(rb_count)
    );

    mr_fifo #(.W(LW), .DEPTH(QDEPTH), .CW(QCW)) u_rlen (
        .clk(clk), .rst_n(rst_n), .push(rl_push), .wdata(q_len),
        .pop(rl_pop), .rdata(rl_len), .count(rl_count)
    );

    always_comb begin
        rs_d     = rs_q;
        sb_rlast = sb_rvalid && ((rs_q.taken + LW'(1)) == rl_len);
        rl_pop   = rb_pop && sb_rlast;
        if (rb_pop) rs_d.taken = sb_rlast ? '0 : rs_q.taken + LW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    mr_issue #(.AW(AW), .LW(LW), .CPU_MAXB(CPU_MAXB), .WCW(BCW)) u_issue (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
        .cpu_req_addr(cpu_req_addr), .cpu_req_len(cpu_req_len),
        .cpu_req_ready(cpu_req_ready), .cpu_err(cpu_err),
        .cpu_wvalid(cpu_wvalid), .cpu_wready(cpu_wready),
        .q_valid(q_valid), .q_write(q_write), .q_addr(q_addr), .q_len(q_len),
        .q_pop(q_pop), .wb_count(wb_count), .wb_pop(wb_pop), .rl_push(rl_push),
        .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_write(dn_write),
        .dn_addr(dn_addr), .dn_tag(dn_tag), .dn_last(dn_last)
    );

    assign dn_wdata = (dn_tag == SRC_CPU) ? cpu_wdata : wb_rdata;

    // R6
    rdata_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sb_rvalid |-> (rl_count != '0));

    // R3
    rbuf_reserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(rb_count) <= 32'(rl_count) * SB_MAXB));
endmodule

// File: tb/tb_mr_arbiter.sv
`timescale 1ns/1ps
module tb_mr_arbiter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sb_req_valid, sb_req_ready, sb_req_write, sb_err;
    logic [31:0] sb_req_addr;
    logic [4:0]  sb_req_len;
    logic        sb_wvalid, sb_wready, sb_rvalid, sb_rready, sb_rlast;
    logic [63:0] sb_wdata, sb_rdata;
    logic        cpu_req_valid, cpu_req_ready, cpu_req_write, cpu_err;
    logic [31:0] cpu_req_addr;
    logic [4:0]  cpu_req_len;
    logic        cpu_wvalid, cpu_wready, cpu_rvalid;
    logic [63:0] cpu_wdata, cpu_rdata;
    logic        dn_valid, dn_ready, dn_write, dn_tag, dn_last;
    logic [31:0] dn_addr;
    logic [63:0] dn_wdata;
    logic        dn_rvalid, dn_rtag;
    logic [63:0] dn_rdata;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    mr_arbiter dut (.*);

    function automatic logic [63:0] rf(input logic [31:0] a);
        return {a, a ^ 32'h5A5A_5A5A};
    endfunction

    // downstream model: fixed 3-cycle read return
    logic        p_v [3];
    logic        p_t [3];
    logic [31:0] p_a [3];
    assign dn_rvalid = p_v[2];
    assign dn_rtag   = p_t[2];
    assign dn_rdata  = rf(p_a[2]);

    // logs
    logic [31:0] la [256];
    logic        lt [256];
    logic        lw [256];
    logic        ll [256];
    logic [63:0] ld [256];
    logic [63:0] sd [256];
    logic        sl [256];
    logic [63:0] cd [256];
    int ln = 0, sn = 0, cn = 0;
    logic [15:0] cw_idx = '0;
    assign cpu_wdata = 64'hC0DE_0000_0000_0000 | 64'(cw_idx);

    always @(posedge clk) begin
        p_v[0] <= rst_n && dn_valid && dn_ready && !dn_write;
        p_t[0] <= dn_tag;
        p_a[0] <= dn_addr;
        for (int i = 1; i < 3; i++) begin
            p_v[i] <= p_v[i-1];
            p_t[i] <= p_t[i-1];
            p_a[i] <= p_a[i-1];
        end
        if (rst_n) begin
            if (dn_valid && dn_ready) begin
                la[ln] <= dn_addr; lt[ln] <= dn_tag; lw[ln] <= dn_write;
                ll[ln] <= dn_last; ld[ln] <= dn_wdata; ln <= ln + 1;
            end
            if (sb_rvalid && sb_rready) begin
                sd[sn] <= sb_rdata; sl[sn] <= sb_rlast; sn <= sn + 1;
            end
            if (cpu_rvalid) begin
                cd[cn] <= cpu_rdata; cn <= cn + 1;
            end
            if (cpu_wready) cw_idx <= cw_idx + 16'd1;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic sb_cmd(input logic w, input logic [31:0] a, input logic [4:0] len,
                          output logic e);
        @(negedge clk);
        sb_req_valid = 1'b1; sb_req_write = w; sb_req_addr = a; sb_req_len = len;
        forever begin
            #1;
            if (sb_req_ready) begin
                e = sb_err;
                @(negedge clk);
                sb_req_valid = 1'b0;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic cpu_cmd(input logic w, input logic [31:0] a, input logic [4:0] len,
                           output logic e);
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_write = w; cpu_req_addr = a; cpu_req_len = len;
        forever begin
            #1;
            if (cpu_req_ready) begin
                e = cpu_err;
                @(negedge clk);
                cpu_req_valid = 1'b0;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        chk("R10 dn_valid", 64'(dn_valid), 64'd0);
        chk("R10 sb_rvalid", 64'(sb_rvalid), 64'd0);
        chk("R10 cpu_req_ready", 64'(cpu_req_ready), 64'd0);
        chk("R10 sb_req_ready", 64'(sb_req_ready), 64'd1);
    endtask

    task automatic t_cpu_read;
        logic e;
        int b = ln, c0 = cn, s0 = sn;
        cpu_cmd(1'b0, 32'h1000, 5'd4, e);
        chk("R7 cpu len 4 accepted", 64'(e), 64'd0);
        repeat (12) @(negedge clk);
        chk("R2 cpu beats", 64'(ln - b), 64'd4);
        for (int i = 0; i < 4; i++) begin
            chk("R8 cpu addr", 64'(la[b+i]), 64'(32'h1000 + 8*i));
            chk("R4 cpu tag", 64'(lt[b+i]), 64'd1);
            chk("R8 cpu last", 64'(ll[b+i]), 64'(i == 3));
            chk("R5 cpu rdata", cd[c0+i], rf(32'h1000 + 8*i));
        end
        chk("R5 cpu returns", 64'(cn - c0), 64'd4);
        chk("R5 read buffer untouched", 64'(sb_rvalid), 64'd0);
        chk("R5 no sb beats", 64'(sn - s0), 64'd0);
    endtask

    task automatic t_sb_read;
        logic e;
        int b = ln, s0 = sn, c0 = cn;
        sb_cmd(1'b0, 32'h2000, 5'd3, e);
        chk("R7 sb len 3 accepted", 64'(e), 64'd0);
        repeat (12) @(negedge clk);
        chk("R6 sb beats", 64'(sn - s0), 64'd3);
        for (int i = 0; i < 3; i++) begin
            chk("R4 sb tag", 64'(lt[b+i]), 64'd0);
            chk("R6 sb rdata", sd[s0+i], rf(32'h2000 + 8*i));
            chk("R6 sb rlast", 64'(sl[s0+i]), 64'(i == 2));
        end
        chk("R4 no cpu returns", 64'(cn - c0), 64'd0);
    endtask

    task automatic t_priority;
        logic e1, e2, e3;
        logic [31:0] ea [5];
        logic        et [5];
        int b = ln, s0 = sn;
        ea = '{32'h4000, 32'h4008, 32'h6000, 32'h5000, 32'h5008};
        et = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
        dn_ready = 1'b0;
        sb_cmd(1'b0, 32'h4000, 5'd2, e1);
        sb_cmd(1'b0, 32'h5000, 5'd2, e2);
        fork
            cpu_cmd(1'b0, 32'h6000, 5'd1, e3);
            begin
                repeat (3) @(negedge clk);
                dn_ready = 1'b1;
            end
        join
        repeat (15) @(negedge clk);
        chk("R1 beat count", 64'(ln - b), 64'd5);
        for (int i = 0; i < 5; i++) begin
            chk("R1 R2 issue order addr", 64'(la[b+i]), 64'(ea[i]));
            chk("R1 issue order tag", 64'(lt[b+i]), 64'(et[i]));
        end
        chk("R6 order A0", sd[s0], rf(32'h4000));
        chk("R6 order A1", sd[s0+1], rf(32'h4008));
        chk("R6 order B0", sd[s0+2], rf(32'h5000));
        chk("R6 last A", 64'(sl[s0+1]), 64'd1);
        chk("R6 not last B0", 64'(sl[s0+2]), 64'd0);
    endtask

    task automatic t_sb_write;
        logic e;
        int b = ln;
        sb_cmd(1'b1, 32'h3000, 5'd4, e);
        repeat (6) @(negedge clk);
        chk("R9 held without data", 64'(ln - b), 64'd0);
        for (int i = 0; i < 4; i++) begin
            sb_wvalid = 1'b1;
            sb_wdata  = 64'h5B00_0000_0000_0000 + 64'(i);
            @(negedge clk);
        end
        sb_wvalid = 1'b0;
        repeat (8) @(negedge clk);
        chk("R9 write beats", 64'(ln - b), 64'd4);
        for (int i = 0; i < 4; i++) begin
            chk("R9 write data", ld[b+i], 64'h5B00_0000_0000_0000 + 64'(i));
            chk("R9 write flag", 64'(lw[b+i]), 64'd1);
            chk("R8 write addr", 64'(la[b+i]), 64'(32'h3000 + 8*i));
        end
    endtask

    task automatic t_cpu_write;
        logic e;
        int b = ln;
        logic [15:0] c0 = cw_idx;
        cpu_cmd(1'b1, 32'h7000, 5'd2, e);
        repeat (6) @(negedge clk);
        chk("R2 cpu write beats", 64'(ln - b), 64'd2);
        for (int i = 0; i < 2; i++) begin
            chk("R4 cpu write tag", 64'(lt[b+i]), 64'd1);
            chk("R4 cpu write data", ld[b+i], 64'hC0DE_0000_0000_0000 | 64'(c0 + 16'(i)));
        end
    endtask

    task automatic t_len_err;
        logic e;
        int b = ln, s0 = sn, c0 = cn;
        sb_cmd(1'b0, 32'h100, 5'd0, e);
        chk("R7 sb len 0", 64'(e), 64'd1);
        sb_cmd(1'b0, 32'h100, 5'd17, e);
        chk("R7 sb len 17", 64'(e), 64'd1);
        cpu_cmd(1'b0, 32'h100, 5'd5, e);
        chk("R7 cpu len 5", 64'(e), 64'd1);
        cpu_cmd(1'b1, 32'h100, 5'd0, e);
        chk("R7 cpu len 0", 64'(e), 64'd1);
        repeat (8) @(negedge clk);
        chk("R7 nothing issued", 64'(ln - b), 64'd0);
        chk("R7 no sb data", 64'(sn - s0), 64'd0);
        chk("R7 no cpu data", 64'(cn - c0), 64'd0);
        chk("R7 queue empty", 64'(sb_req_ready), 64'd1);
    endtask

    task automatic t_capacity;
        logic e;
        int b = ln, s0 = sn;
        sb_rready = 1'b0;
        sb_cmd(1'b0, 32'h8000, 5'd16, e);
        chk("R7 sb len 16 accepted", 64'(e), 64'd0);
        sb_cmd(1'b0, 32'h9000, 5'd16, e);
        sb_cmd(1'b0, 32'hA000, 5'd1, e);
        sb_cmd(1'b0, 32'hB000, 5'd2, e);
        repeat (50) @(negedge clk);
        chk("R3 full blocks", 64'(sb_req_ready), 64'd0);
        chk("R2 all issued", 64'(ln - b), 64'd35);
        chk("R8 16th addr", 64'(la[b+15]), 64'h8078);
        chk("R8 16th last", 64'(ll[b+15]), 64'd1);
        chk("R8 15th not last", 64'(ll[b+14]), 64'd0);
        sb_rready = 1'b1;
        repeat (15) @(negedge clk);
        chk("R3 still full", 64'(sb_req_ready), 64'd0);
        @(negedge clk);
        chk("R3 slot freed", 64'(sb_req_ready), 64'd1);
        repeat (30) @(negedge clk);
        chk("R6 drained", 64'(sn - s0), 64'd35);
        chk("R6 second txn", sd[s0+16], rf(32'h9000));
        chk("R6 third txn", sd[s0+32], rf(32'hA000));
        chk("R6 third last", 64'(sl[s0+32]), 64'd1);
        chk("R6 final beat", sd[s0+34], rf(32'hB008));
        chk("R6 final last", 64'(sl[s0+34]), 64'd1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        sb_req_valid = 0; sb_req_write = 0; sb_req_addr = '0; sb_req_len = '0;
        sb_wvalid = 0; sb_wdata = '0; sb_rready = 1;
        cpu_req_valid = 0; cpu_req_write = 0; cpu_req_addr = '0; cpu_req_len = '0;
        cpu_wvalid = 1; dn_ready = 1;
        for (int i = 0; i < 3; i++) begin p_v[i] = 0; p_t[i] = 0; p_a[i] = '0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cpu_read();
        t_sb_read();
        t_priority();
        t_sb_write();
        t_cpu_write();
        t_len_err();
        t_capacity();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule